// File: doc/BRIEF.md
# Soft-ramp zero-cross volume controller

This block keeps the present attenuation of a two-channel audio path and walks each channel's attenuation code toward a requested target. Codes are unsigned values in 1/8 dB units. The smallest code means no attenuation and the all-ones code means mute. A one-clock sample strobe marks each new pair of signed samples.

Four settings choose how a level change is made:
- Neither soft ramping nor zero-cross gating: the change is applied at once.
- Soft ramping only: one 1/8 dB step is taken per sample.
- Zero-cross gating only: the whole change waits for the channel's next zero crossing.
- Both: each single step waits for a crossing.

A pending change that sees no crossing is forced after 512 sample strobes. Crossing detection and timeouts are kept per channel.

A filter-change request starts a sequence. Both channels are first brought to mute, either ramped or at once. A one-clock grant is issued while both sit at mute. The channels then return to their targets, either ramped or at once. The downstream datapath reads the attenuation codes and the grant. It turns codes into gain and performs the filter switch itself.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: Each channel's code is ATT_W bits (default 8) in 1/8 dB units: 0 is no attenuation and 255 (all ones) is mute. While reset is asserted both codes read 255 and `filt_grant` reads 0.
- R2: With `soft_en`=0 and `zc_en`=0, and no sequencer force active, each code equals its effective target on the clock edge after the target is presented.
- R3: With `soft_en`=1 and `zc_en`=0, a code differing from its target moves by exactly 1 toward it on each clock where `smp_stb`=1, and is unchanged on other clocks.
- R4: With `soft_en`=0 and `zc_en`=1, a code differing from its target is unchanged until a strobe that carries a zero crossing for that channel (or the timeout). On that strobe it takes the full target value.
- R5: With `soft_en`=1 and `zc_en`=1, a code moves by exactly 1 toward its target on each strobe that carries a zero crossing for that channel (or the timeout), and is unchanged otherwise.
- R6: A channel sees a zero crossing on a strobe when its sample is exactly 0, or when its sign bit (MSB, two's complement) differs from the sign bit of that channel's previous strobed sample. After reset the previous sign is taken as non-negative. Each channel is evaluated independently.
- R7: With `zc_en`=1, a change pending for 512 strobes without a crossing is forced: no step on strobes 1 to 511 after the change became pending, and a step on strobe 512.
- R8: While `mute_req`=1 each channel's effective target is 255.
- R9: A `filt_req` pulse while idle makes 255 the effective target of both channels. With `dn_ramp`=1 they reach it under the current mode rules. With `dn_ramp`=0 both codes read 255 after the second clock edge following the request.
- R10: `filt_grant` is high for exactly one clock, only while both codes are 255. It rises one clock after both codes first reach 255 in the mute phase.
- R11: After the grant, with `up_ramp`=1 the channels return to their targets under the current mode rules. With `up_ramp`=0 both codes equal their targets on the clock edge that ends the grant.
- R12: `ramp_done` is 1 exactly when both codes equal their effective targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-clock sample strobe |
| smp_i | input | NCH*SMP_W | Signed samples, channel 0 in the low slice |
| tgt_i | input | NCH*ATT_W | Target attenuation per channel |
| mute_req | input | 1 | Force mute as target |
| soft_en | input | 1 | Step in 1/8 dB increments |
| zc_en | input | 1 | Gate changes on zero crossings |
| up_ramp | input | 1 | Ramp back after a filter change |
| dn_ramp | input | 1 | Ramp to mute before a filter change |
| filt_req | input | 1 | Filter-change request pulse |
| att_o | output | NCH*ATT_W | Current attenuation per channel |
| ramp_done | output | 1 | Both channels at their targets |
| filt_grant | output | 1 | One-clock filter-change grant |

## Verification
The assertions assume `smp_stb` is a single-cycle marker and that the mode bits are sampled on the same edge that applies the step. They therefore relate each code change to the mode and strobe seen one clock earlier, and they exclude the two sequencer forces, which are allowed to jump. The stimulus keeps the strobe on a fixed four-clock cadence and changes all other inputs just after a rising edge. This makes every input stable across the edge that consumes it. Random segments vary the crossing rate down to none so that timeouts occur. Filter requests stay short pulses, and a request that arrives while a sequence is running is simply not accepted.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DOWN  = 2'd1,
    SQ_GRANT = 2'd2
  } seq_e;
endpackage

// File: rtl/vr_zcdet.sv
module vr_zcdet #(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [SMP_W-1:0] smp,
  output logic             zc
);
  logic neg_q;
  logic neg_d;

  always_comb begin
    neg_d = neg_q;
    if (smp_stb) neg_d = smp[SMP_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= neg_d;
  end

  // crossing: exact zero, or sign flip against the previous strobed sample
  assign zc = smp_stb && ((smp == '0) || (smp[SMP_W-1] != neg_q));
endmodule

// File: rtl/vr_chan.sv
module vr_chan #(
  parameter int ATT_W = 8,
  parameter int TMO   = 512,
  localparam int CNT_W = $clog2(TMO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             zc,
  input  logic             soft_en,
  input  logic             zc_en,
  input  logic             frc_mute,
  input  logic             frc_load,
  input  logic [ATT_W-1:0] tgt,
  output logic [ATT_W-1:0] cur,
  output logic [CNT_W-1:0] tmo_cnt
);
  localparam logic [ATT_W-1:0] MUTE = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO - 1);

  logic [ATT_W-1:0] cur_q, cur_d, toward;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend, tmo_hit;

  always_comb begin
    pend    = (cur_q != tgt);
    tmo_hit = smp_stb && (cnt_q == CNT_LAST);
    toward  = (cur_q < tgt) ? cur_q + 1'b1 : cur_q - 1'b1;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    if (frc_mute) begin
      cur_d = MUTE;
      cnt_d = '0;
    end else if (frc_load) begin
      cur_d = tgt;
      cnt_d = '0;
    end else if (!pend) begin
      cnt_d = '0;
    end else if (!soft_en && !zc_en) begin
      cur_d = tgt;
      cnt_d = '0;
    end else if (!zc_en) begin
      if (smp_stb) cur_d = toward;
      cnt_d = '0;
    end else if (zc || tmo_hit) begin
      cur_d = soft_en ? toward : tgt;
      cnt_d = '0;
    end else if (smp_stb) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MUTE;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign cur     = cur_q;
  assign tmo_cnt = cnt_q;
endmodule

// File: rtl/vr_seq.sv
module vr_seq
  import vr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic filt_req,
  input  logic dn_ramp,
  input  logic up_ramp,
  input  logic all_mute,
  output logic hold_mute,
  output logic frc_mute,
  output logic frc_load,
  output logic grant
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE:  if (filt_req) st_d = SQ_DOWN;
      SQ_DOWN:  if (all_mute) st_d = SQ_GRANT;
      SQ_GRANT: st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign hold_mute = (st_q == SQ_DOWN);
  assign frc_mute  = (st_q == SQ_DOWN) && !dn_ramp;
  assign frc_load  = (st_q == SQ_GRANT) && !up_ramp;
  assign grant     = (st_q == SQ_GRANT);
endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl #(
  parameter int NCH   = 2,
  parameter int SMP_W = 24,
  parameter int ATT_W = 8,
  parameter int TMO   = 512,
  localparam int CNT_W = $clog2(TMO)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic [NCH*SMP_W-1:0] smp_i,
  input  logic [NCH*ATT_W-1:0] tgt_i,
  input  logic                 mute_req,
  input  logic                 soft_en,
  input  logic                 zc_en,
  input  logic                 up_ramp,
  input  logic                 dn_ramp,
  input  logic                 filt_req,
  output logic [NCH*ATT_W-1:0] att_o,
  output logic                 ramp_done,
  output logic                 filt_grant
);
  localparam logic [ATT_W-1:0] MUTE = '1;

  logic [NCH*ATT_W-1:0] eff_flat;
  logic [NCH*CNT_W-1:0] tmo_flat;
  logic [NCH-1:0]       at_mute, at_tgt, zc_v;
  logic                 hold_mute, frc_mute, frc_load, all_mute;

  assign all_mute = &at_mute;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ATT_W-1:0] cur;
    assign eff_flat[c*ATT_W +: ATT_W] =
      (mute_req || hold_mute) ? MUTE : tgt_i[c*ATT_W +: ATT_W];

    vr_zcdet #(.SMP_W(SMP_W)) u_zc (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_stb (smp_stb),
      .smp     (smp_i[c*SMP_W +: SMP_W]),
      .zc      (zc_v[c])
    );

    vr_chan #(.ATT_W(ATT_W), .TMO(TMO)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_stb  (smp_stb),
      .zc       (zc_v[c]),
      .soft_en  (soft_en),
      .zc_en    (zc_en),
      .frc_mute (frc_mute),
      .frc_load (frc_load),
      .tgt      (eff_flat[c*ATT_W +: ATT_W]),
      .cur      (cur),
      .tmo_cnt  (tmo_flat[c*CNT_W +: CNT_W])
    );

    assign att_o[c*ATT_W +: ATT_W] = cur;
    assign at_mute[c] = (cur == MUTE);
    assign at_tgt[c]  = (cur == eff_flat[c*ATT_W +: ATT_W]);
  end

  vr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt_req  (filt_req),
    .dn_ramp   (dn_ramp),
    .up_ramp   (up_ramp),
    .all_mute  (all_mute),
    .hold_mute (hold_mute),
    .frc_mute  (frc_mute),
    .frc_load  (frc_load),
    .grant     (filt_grant)
  );

  assign ramp_done = &at_tgt;
endmodule

// File: rtl/vr_chk.sv
module vr_chk #(
  parameter int NCH   = 2,
  parameter int ATT_W = 8,
  parameter int TMO   = 512,
  localparam int CNT_W = $clog2(TMO)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic                 soft_en,
  input logic                 zc_en,
  input logic                 frc_mute,
  input logic                 frc_load,
  input logic                 filt_grant,
  input logic [NCH*ATT_W-1:0] att,
  input logic [NCH*ATT_W-1:0] eff,
  input logic [NCH*CNT_W-1:0] tmo
);
  localparam logic [ATT_W-1:0] MUTE = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO - 1);

  function automatic logic near(input logic [ATT_W-1:0] a, input logic [ATT_W-1:0] b);
    near = (a == b) || ((a == b + 1'b1) && (a != '0)) || ((b == a + 1'b1) && (b != '0));
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R3 / R5: soft mode never moves more than one code per clock
    p_soft_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      soft_en && !frc_mute && !frc_load
      |=> near(att[c*ATT_W +: ATT_W], $past(att[c*ATT_W +: ATT_W])));

    // R5: gated or soft modes leave the code alone between strobes
    p_hold_nostb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_en || zc_en) && !smp_stb && !frc_mute && !frc_load
      |=> $stable(att[c*ATT_W +: ATT_W]));

    // R2: direct mode lands on the effective target in one clock
    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_en && !zc_en && !frc_mute && !frc_load
      |=> att[c*ATT_W +: ATT_W] == $past(eff[c*ATT_W +: ATT_W]));

    // R7: an expired timeout on a strobe forces a step
    p_tmo_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      zc_en && smp_stb && !frc_mute && !frc_load &&
      (tmo[c*CNT_W +: CNT_W] == CNT_LAST) &&
      (att[c*ATT_W +: ATT_W] != eff[c*ATT_W +: ATT_W])
      |=> att[c*ATT_W +: ATT_W] != $past(att[c*ATT_W +: ATT_W]));

    // R9: immediate mute policy reaches full mute next clock
    p_force_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frc_mute |=> att[c*ATT_W +: ATT_W] == MUTE);

    // R10: grant only while muted
    p_grant_muted_r10: assert property (@(posedge clk) disable iff (!rst_n)
      filt_grant |-> att[c*ATT_W +: ATT_W] == MUTE);
  end

  // R10: grant is a single-clock pulse
  p_grant_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    filt_grant |=> !filt_grant);
endmodule

bind vol_ramp_ctrl vr_chk #(.NCH(NCH), .ATT_W(ATT_W), .TMO(TMO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_stb    (smp_stb),
  .soft_en    (soft_en),
  .zc_en      (zc_en),
  .frc_mute   (frc_mute),
  .frc_load   (frc_load),
  .filt_grant (filt_grant),
  .att        (att_o),
  .eff        (eff_flat),
  .tmo        (tmo_flat)
);

// File: tb/vol_ramp_ctrl_bench.sv
module vol_ramp_ctrl_bench;
  localparam int NCH = 2, SMP_W = 24, ATT_W = 8, TMO = 512;
  localparam int MUTE = 255;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, smp_stb, mute_req, soft_en, zc_en, up_ramp, dn_ramp, filt_req;
  logic [SMP_W-1:0] smp [NCH];
  logic [ATT_W-1:0] tgt [NCH];
  logic [NCH*SMP_W-1:0] smp_i;
  logic [NCH*ATT_W-1:0] tgt_i, att_o;
  logic ramp_done, filt_grant;

  for (genvar c = 0; c < NCH; c++) begin : g_pk
    assign smp_i[c*SMP_W +: SMP_W] = smp[c];
    assign tgt_i[c*ATT_W +: ATT_W] = tgt[c];
  end

  vol_ramp_ctrl #(.NCH(NCH), .SMP_W(SMP_W), .ATT_W(ATT_W), .TMO(TMO)) u_vol_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_i(smp_i), .tgt_i(tgt_i),
    .mute_req(mute_req), .soft_en(soft_en), .zc_en(zc_en), .up_ramp(up_ramp),
    .dn_ramp(dn_ramp), .filt_req(filt_req), .att_o(att_o), .ramp_done(ramp_done),
    .filt_grant(filt_grant)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int att(input int c);
    return int'(att_o[c*ATT_W +: ATT_W]);
  endfunction

  // ---------------- reference model from the requirements ----------------
  int m_cur [NCH];
  int m_cnt [NCH];
  bit m_neg [NCH];
  int m_st;  // 0 idle, 1 mute phase, 2 grant

  function automatic int m_eff(input int c);
    if (mute_req || m_st == 1) return MUTE;             // R8, R9
    return int'(tgt[c]);
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    int nc [NCH];
    int nn [NCH];
    bit zc, allm;
    int e;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_cur[c] <= MUTE; m_cnt[c] <= 0; m_neg[c] <= 1'b0;
      end
      m_st <= 0;
    end else begin
      allm = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        if (m_cur[c] != MUTE) allm = 1'b0;
        e  = m_eff(c);
        zc = smp_stb && ((smp[c] == '0) || (smp[c][SMP_W-1] != m_neg[c]));
        nc[c] = m_cur[c];
        nn[c] = m_cnt[c];
        if (m_st == 1 && !dn_ramp) begin nc[c] = MUTE; nn[c] = 0; end
        else if (m_st == 2 && !up_ramp) begin nc[c] = e; nn[c] = 0; end
        else if (m_cur[c] == e) nn[c] = 0;
        else if (!soft_en && !zc_en) begin nc[c] = e; nn[c] = 0; end
        else if (!zc_en) begin
          if (smp_stb) nc[c] = (m_cur[c] < e) ? m_cur[c] + 1 : m_cur[c] - 1;
          nn[c] = 0;
        end else if (zc || (smp_stb && m_cnt[c] == TMO - 1)) begin
          nc[c] = soft_en ? ((m_cur[c] < e) ? m_cur[c] + 1 : m_cur[c] - 1) : e;
          nn[c] = 0;
        end else if (smp_stb) nn[c] = m_cnt[c] + 1;
        if (smp_stb) m_neg[c] <= smp[c][SMP_W-1];
        m_cur[c] <= nc[c];
        m_cnt[c] <= nn[c];
      end
      case (m_st)
        0: if (filt_req) m_st <= 1;
        1: if (allm) m_st <= 2;
        default: m_st <= 0;
      endcase
    end
  end

  function automatic string mode_tag();
    if (m_st == 1) return "R9";
    if (m_st == 2) return "R11";
    if (soft_en && zc_en) return "R5";
    if (soft_en) return "R3";
    if (zc_en) return "R4";
    return "R2";
  endfunction

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_en && !finished) begin
      bit dn;
      dn = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        check(mode_tag(), att(c), m_cur[c]);
        if (m_cur[c] != m_eff(c)) dn = 1'b0;
      end
      check("R10", int'(filt_grant), int'(m_st == 2));
      check("R12", int'(ramp_done), int'(dn));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic strobe(input int s0, input int s1);
    smp[0] = SMP_W'(s0); smp[1] = SMP_W'(s1); smp_stb = 1'b1;
    tick();
    smp_stb = 1'b0;
    tick(); tick(); tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int nstb;
    bit seen;
    bit neg_r [NCH];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; smp_stb = 1'b0; mute_req = 1'b0; soft_en = 1'b0; zc_en = 1'b0;
    up_ramp = 1'b1; dn_ramp = 1'b1; filt_req = 1'b0;
    smp[0] = SMP_W'(5); smp[1] = SMP_W'(5);
    tgt[0] = 8'd255; tgt[1] = 8'd255;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset att0", att(0), 255);
    check("R1 reset att1", att(1), 255);
    check("R1 reset grant", int'(filt_grant), 0);
    rst_n = 1'b1;
    cmp_en = 1;
    check("R12 done at reset targets", int'(ramp_done), 1);

    // R2 direct mode
    tgt[0] = 8'd40; tgt[1] = 8'd60;
    #0.1 check("R12 done low while pending", int'(ramp_done), 0);
    tick();
    check("R2 att0", att(0), 40);
    check("R2 att1", att(1), 60);

    // R3 soft ramp per strobe
    soft_en = 1'b1; tgt[0] = 8'd44;
    strobe(5, 5);
    check("R3 one step", att(0), 41);
    repeat (3) strobe(5, 5);
    check("R3 reached", att(0), 44);
    check("R3 other channel", att(1), 60);

    // R8 mute request
    soft_en = 1'b0; mute_req = 1'b1;
    tick();
    check("R8 att0", att(0), 255);
    check("R8 att1", att(1), 255);

    // R4 / R6 zero-cross only, per channel
    mute_req = 1'b0; zc_en = 1'b1;
    strobe(5, 5);
    check("R4 no crossing holds", att(0), 255);
    strobe(-5, 5);
    check("R4 full jump on crossing", att(0), 44);
    check("R6 other channel waits", att(1), 255);
    strobe(-5, -5);
    check("R6 own crossing", att(1), 60);

    // R5 / R6 soft + zero cross
    soft_en = 1'b1; tgt[0] = 8'd40; tgt[1] = 8'd62;
    strobe(3, -3);
    check("R5 step on crossing", att(0), 43);
    check("R5 no step without crossing", att(1), 60);
    strobe(0, -3);
    check("R6 zero sample counts", att(0), 42);

    // R7 timeout
    soft_en = 1'b0; zc_en = 1'b0;
    tick();
    strobe(-7, -7); strobe(-7, -7);
    zc_en = 1'b1; tgt[0] = 8'd200; tgt[1] = 8'd200;
    repeat (TMO - 1) strobe(-7, -7);
    check("R7 before timeout att0", att(0), 40);
    check("R7 before timeout att1", att(1), 62);
    strobe(-7, -7);
    check("R7 at timeout att0", att(0), 200);
    check("R7 at timeout att1", att(1), 200);

    // R9 / R10 / R11 immediate policies
    zc_en = 1'b0; tgt[0] = 8'd50; tgt[1] = 8'd70;
    tick();
    soft_en = 1'b1; dn_ramp = 1'b0; up_ramp = 1'b0; filt_req = 1'b1;
    tick();
    filt_req = 1'b0;
    tick();
    check("R9 immediate mute att0", att(0), 255);
    check("R9 immediate mute att1", att(1), 255);
    tick();
    check("R10 grant high", int'(filt_grant), 1);
    tick();
    check("R10 grant one clock", int'(filt_grant), 0);
    check("R11 immediate unmute att0", att(0), 50);
    check("R11 immediate unmute att1", att(1), 70);

    // R9 / R10 / R11 ramped policies
    soft_en = 1'b0; tgt[0] = 8'd250; tgt[1] = 8'd252;
    tick();
    soft_en = 1'b1; dn_ramp = 1'b1; up_ramp = 1'b1; filt_req = 1'b1;
    tick();
    filt_req = 1'b0;
    nstb = 0; seen = 0;
    for (int i = 0; i < 80; i++) begin
      tick();
      smp_stb = 1'b0;
      if (filt_grant) begin seen = 1; break; end
      if (i % 4 == 0) begin smp_stb = 1'b1; nstb++; end
    end
    check("R10 grant issued", int'(seen), 1);
    check("R10 grant while muted", att(0) + att(1), 510);
    check("R9 ramped over five strobes", int'(nstb >= 5), 1);
    strobe(5, 5);
    check("R11 ramp up att0", att(0), 254);
    check("R11 ramp up att1", att(1), 254);

    // random phase
    neg_r[0] = 1'b0; neg_r[1] = 1'b0;
    for (int seg = 0; seg < 10; seg++) begin
      int rate;
      soft_en = 1'($urandom % 2); zc_en = 1'($urandom % 2);
      dn_ramp = 1'($urandom % 2); up_ramp = 1'($urandom % 2);
      rate = int'($urandom % 4);
      for (int i = 0; i < 3000; i++) begin
        tick();
        smp_stb = 1'b0; filt_req = 1'b0;
        if (i % 4 == 0) begin
          smp_stb = 1'b1;
          for (int c = 0; c < NCH; c++) begin
            int mag;
            if (int'($urandom % 8) < rate) neg_r[c] = ~neg_r[c];
            mag = int'($urandom % 1000) + 1;
            smp[c] = neg_r[c] ? SMP_W'(-mag) : SMP_W'(mag);
            if ($urandom % 64 == 0) smp[c] = '0;
          end
        end
        for (int c = 0; c < NCH; c++)
          if ($urandom % 200 == 0) tgt[c] = 8'($urandom % 256);
        if ($urandom % 500 == 0) mute_req = ~mute_req;
        if ($urandom % 400 == 0) filt_req = 1'b1;
      end
    end
    tick();
    summary();
  end
endmodule